// File: doc/BRIEF.md
# I2C Slave Masked Address Recognizer

This block is the address stage of an I2C slave. It takes the raw SCL and SDA lines and synchronizes them into the system clock domain. It finds START and STOP conditions on the synchronized lines, then shifts in the first byte after a START. That byte holds a 7-bit address followed by a direction bit. Once the byte is in, the block decides whether to acknowledge it. The decision uses a 7-bit own address and a 7-bit mask. A mask bit of 1 takes that address bit out of the compare, so one slave can answer a whole group of addresses. The block can also answer the all-zero general-call address when that response is enabled.

On a match, the block holds SCL low and raises a request toward the host logic. The host grants the acknowledge by raising `ackAllow`. The block then pulls SDA low, releases SCL, and holds SDA low until the falling edge of SCL that ends the ninth clock. With each match it reports:
- the exact 7-bit address that was received;
- the direction bit;
- whether the general-call address was the one that hit.

The host can therefore tell which member of the masked group was addressed. Both bus outputs are open-drain enables: a 1 means pull the line low. Other slaves that acknowledge at the same time simply combine with this one as a wired-AND.

Top module: `i2c_mask_addr_slave`

## Requirements
- R1: With a mask of all zeros, the block acknowledges only an incoming address equal to `ownAddr` bit for bit. Any other address, including one that differs in bit 0 only, is not acknowledged.
- R2: Address bits whose mask bit is 1 are excluded from the compare. With mask 0000011 and own address 0000100, the addresses 0000100, 0000110 and 0000111 are acknowledged, and 0001100 is not.
- R3: While `gcEnable` is 1, address 0000000 is acknowledged whatever the own address and mask are, and `gcHit` reads 1 for that transfer. On a match through the own address alone, `gcHit` reads 0.
- R4: While `gcEnable` is 0, address 0000000 is acknowledged only if it passes the masked own-address compare. After a mismatch, `sdaOe` stays 0 until the next START.
- R5: On every match, `rxAddr` holds the received 7-bit address and `rxRw` holds the eighth bit. Both are valid from the time `ackReq` rises. A mismatched transfer leaves `rxAddr`, `rxRw` and `gcHit` unchanged.
- R6: After a match and the falling edge of the eighth SCL clock, `sclOe` and `ackReq` stay 1 for as long as `ackAllow` is 0. `sdaOe` stays 0 until `ackAllow` is 1.
- R7: `sdaOe` rises no later than the cycle in which `sclOe` falls. `sdaOe` returns to 0 within a few system clocks of the falling SCL edge that ends the ninth clock.
- R8: A START seen while SCL is high restarts address reception, including partway through a byte (repeated START). Only the full byte that follows it is decoded.
- R9: SCL clocks that arrive after a STOP, or after reset, without a START in between, are ignored. No acknowledge is driven for them.
- R10: Address bits are taken on rising SCL edges, most significant bit first. The eighth bit is the direction bit, where 1 means read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8 times the SCL rate |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Raw SCL line level |
| sdaIn | input | 1 | Raw SDA line level |
| ownAddr | input | 7 | Own slave address |
| addrMask | input | 7 | Per-bit don't-care mask (1 = ignore that bit) |
| gcEnable | input | 1 | Enables the general-call response |
| ackAllow | input | 1 | Host grant to drive the acknowledge |
| sdaOe | output | 1 | Pull SDA low when 1 |
| sclOe | output | 1 | Pull SCL low (clock stretch) when 1 |
| ackReq | output | 1 | Match found, acknowledge awaiting `ackAllow` |
| rxAddr | output | 7 | Address of the last matched transfer |
| rxRw | output | 1 | Direction bit of the last matched transfer |
| gcHit | output | 1 | Last match was through the general-call address |

## Verification
Several internal faults all become visible at the acknowledge slot, one SCL period after the fault:
- a wrong bit count;
- a shift in the wrong direction;
- a compare that ignores the mask.

They show up as a missing or spurious low on SDA, or as a reported address that differs from the one sent. A controller stuck in the stretch state holds SCL low indefinitely. A controller that leaves the acknowledge state too early or too late releases SDA outside the few system clocks that follow the ninth falling edge. A decoder that misses a START or STOP shows up as an acknowledge to a byte that had no valid START before it, or as no acknowledge after a repeated START.

// File: rtl/i2c_mask_addr_pkg.sv
package i2c_mask_addr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_DECIDE,
    ST_STRETCH,
    ST_ACK
  } slvState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic clrCnt;
    logic shiftEn;
    logic capture;
  } ctrlStrb_t;

endpackage

// File: rtl/i2c_mask_addr_dp.sv
module i2c_mask_addr_dp
  import i2c_mask_addr_pkg::*;
#(
  parameter int ADDR_W      = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic [ADDR_W-1:0] ownAddr,
  input  logic [ADDR_W-1:0] addrMask,
  input  logic              gcEnable,
  input  ctrlStrb_t         strb,
  output logic              startDet,
  output logic              stopDet,
  output logic              sclRise,
  output logic              sclFall,
  output logic              byteDone,
  output logic              addrMatch,
  output logic [ADDR_W-1:0] rxAddr,
  output logic              rxRw,
  output logic              gcHit
);

  localparam int BYTE_W = ADDR_W + 1;
  localparam int CNT_W  = $clog2(BYTE_W + 1);
  localparam int LINES  = 2;

  logic [LINES-1:0] lineRaw;
  logic [LINES-1:0] lineSync;
  logic [LINES-1:0] linePrev;

  assign lineRaw = {sdaIn, sclIn};

  // one synchronizer chain per bus line, reset to the idle-high level
  for (genvar g = 0; g < LINES; g++) begin : g_sync
    logic [SYNC_STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) chain <= '1;
      else       chain <= {chain[SYNC_STAGES-2:0], lineRaw[g]};
    end
    assign lineSync[g] = chain[SYNC_STAGES-1];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) linePrev <= '1;
    else       linePrev <= lineSync;
  end

  logic sclNow, sdaNow, sclOld, sdaOld;
  assign sclNow = lineSync[0];
  assign sdaNow = lineSync[1];
  assign sclOld = linePrev[0];
  assign sdaOld = linePrev[1];

  assign sclRise  = sclNow & ~sclOld;
  assign sclFall  = ~sclNow & sclOld;
  assign startDet = sclNow & sclOld & sdaOld & ~sdaNow;
  assign stopDet  = sclNow & sclOld & ~sdaOld & sdaNow;

  logic [BYTE_W-1:0] shiftReg;
  logic [CNT_W-1:0]  bitCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      bitCnt   <= '0;
    end else if (strb.clrCnt) begin
      bitCnt   <= '0;
    end else if (strb.shiftEn) begin
      shiftReg <= {shiftReg[BYTE_W-2:0], sdaNow};
      bitCnt   <= bitCnt + 1'b1;
    end
  end

  assign byteDone = (bitCnt == CNT_W'(BYTE_W));

  logic [ADDR_W-1:0] candAddr;
  logic              ownMatch, gcMatch;

  assign candAddr  = shiftReg[BYTE_W-1:1];
  assign ownMatch  = ((candAddr ^ ownAddr) & ~addrMask) == '0;
  assign gcMatch   = gcEnable && (candAddr == '0);
  assign addrMatch = ownMatch | gcMatch;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxAddr <= '0;
      rxRw   <= 1'b0;
      gcHit  <= 1'b0;
    end else if (strb.capture) begin
      rxAddr <= candAddr;
      rxRw   <= shiftReg[0];
      gcHit  <= gcMatch;
    end
  end

endmodule

// File: rtl/i2c_mask_addr_ctrl.sv
module i2c_mask_addr_ctrl
  import i2c_mask_addr_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      startDet,
  input  logic      stopDet,
  input  logic      sclRise,
  input  logic      sclFall,
  input  logic      byteDone,
  input  logic      addrMatch,
  input  logic      ackAllow,
  output ctrlStrb_t strb,
  output logic      sdaOe,
  output logic      sclOe,
  output logic      ackReq
);

  slvState_t state, stateNxt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNxt;
  end

  always_comb begin
    stateNxt     = state;
    strb         = '0;
    if (startDet) begin
      stateNxt    = ST_ADDR;
      strb.clrCnt = 1'b1;
    end else if (stopDet) begin
      stateNxt = ST_IDLE;
    end else begin
      unique case (state)
        ST_IDLE: stateNxt = ST_IDLE;
        ST_ADDR: begin
          if (byteDone)     stateNxt = ST_DECIDE;
          else if (sclRise) strb.shiftEn = 1'b1;
        end
        ST_DECIDE: begin
          if (sclFall) begin
            if (addrMatch) begin
              strb.capture = 1'b1;
              stateNxt     = ST_STRETCH;
            end else begin
              stateNxt = ST_IDLE;
            end
          end
        end
        ST_STRETCH: if (ackAllow) stateNxt = ST_ACK;
        ST_ACK:     if (sclFall)  stateNxt = ST_IDLE;
        default:    stateNxt = ST_IDLE;
      endcase
    end
  end

  assign ackReq = (state == ST_STRETCH);
  assign sclOe  = (state == ST_STRETCH);
  assign sdaOe  = (state == ST_ACK) || ((state == ST_STRETCH) && ackAllow);

endmodule

// File: rtl/i2c_mask_addr_slave.sv
module i2c_mask_addr_slave
  import i2c_mask_addr_pkg::*;
#(
  parameter int ADDR_W      = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic [ADDR_W-1:0] ownAddr,
  input  logic [ADDR_W-1:0] addrMask,
  input  logic              gcEnable,
  input  logic              ackAllow,
  output logic              sdaOe,
  output logic              sclOe,
  output logic              ackReq,
  output logic [ADDR_W-1:0] rxAddr,
  output logic              rxRw,
  output logic              gcHit
);

  ctrlStrb_t strb;
  logic startDet, stopDet, sclRise, sclFall, byteDone, addrMatch;

  i2c_mask_addr_dp #(
    .ADDR_W(ADDR_W),
    .SYNC_STAGES(SYNC_STAGES)
  ) dp_i (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .ownAddr(ownAddr), .addrMask(addrMask), .gcEnable(gcEnable),
    .strb(strb), .startDet(startDet), .stopDet(stopDet),
    .sclRise(sclRise), .sclFall(sclFall), .byteDone(byteDone),
    .addrMatch(addrMatch), .rxAddr(rxAddr), .rxRw(rxRw), .gcHit(gcHit)
  );

  i2c_mask_addr_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .startDet(startDet), .stopDet(stopDet),
    .sclRise(sclRise), .sclFall(sclFall), .byteDone(byteDone),
    .addrMatch(addrMatch), .ackAllow(ackAllow), .strb(strb),
    .sdaOe(sdaOe), .sclOe(sclOe), .ackReq(ackReq)
  );

endmodule

// File: rtl/i2c_mask_addr_checker.sv
module i2c_mask_addr_checker #(
  parameter int ADDR_W = 7
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] ownAddr,
  input logic [ADDR_W-1:0] addrMask,
  input logic              gcEnable,
  input logic              ackAllow,
  input logic              sdaOe,
  input logic              sclOe,
  input logic              ackReq,
  input logic [ADDR_W-1:0] rxAddr,
  input logic              gcHit
);

  // R1 R2 R3: a pending acknowledge always refers to an address that passes the masked or general-call compare
  p_req_matches_r2: assert property (@(posedge clk) disable iff (!rstN)
    ackReq |-> ((((rxAddr ^ ownAddr) & ~addrMask) == '0) || (gcEnable && rxAddr == '0)));

  // R3: the general-call flag only accompanies an all-zero address
  p_gc_zero_addr_r3: assert property (@(posedge clk) disable iff (!rstN)
    (ackReq && gcHit) |-> (rxAddr == '0));

  // R6: SDA is never pulled before the host grants it
  p_sda_after_allow_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaOe) |-> ackAllow);

  // R6: the request is held together with the clock stretch
  p_req_stretch_r6: assert property (@(posedge clk) disable iff (!rstN)
    ackReq |-> sclOe);

  // R7: SCL is released only with SDA already pulled low
  p_sda_before_release_r7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sclOe) |-> $past(sdaOe));

endmodule

bind i2c_mask_addr_slave i2c_mask_addr_checker #(.ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rstN(rstN), .ownAddr(ownAddr), .addrMask(addrMask),
  .gcEnable(gcEnable), .ackAllow(ackAllow), .sdaOe(sdaOe), .sclOe(sclOe),
  .ackReq(ackReq), .rxAddr(rxAddr), .gcHit(gcHit)
);

// File: tb/i2c_mask_addr_slave_tb.sv
module i2c_mask_addr_slave_tb_top;

  localparam int H = 10;  // system clocks per SCL half period
  localparam int NV = 9;

  // {mask[24:18], own[17:11], gcEn[10], addr[9:3], rw[2], expAck[1], expGc[0]}
  localparam logic [24:0] VEC [NV] = '{
    {7'b0000011, 7'b0000100, 1'b0, 7'b0000100, 1'b0, 1'b1, 1'b0},
    {7'b0000011, 7'b0000100, 1'b0, 7'b0000111, 1'b1, 1'b1, 1'b0},
    {7'b0000011, 7'b0000100, 1'b0, 7'b0000110, 1'b0, 1'b1, 1'b0},
    {7'b0000011, 7'b0000100, 1'b0, 7'b0001100, 1'b1, 1'b0, 1'b0},
    {7'b0000000, 7'b1010101, 1'b0, 7'b1010101, 1'b1, 1'b1, 1'b0},
    {7'b0000000, 7'b1010101, 1'b0, 7'b1010100, 1'b0, 1'b0, 1'b0},
    {7'b0000000, 7'b1010101, 1'b1, 7'b0000000, 1'b0, 1'b1, 1'b1},
    {7'b0000000, 7'b1010101, 1'b0, 7'b0000000, 1'b0, 1'b0, 1'b0},
    {7'b1111111, 7'b0011001, 1'b0, 7'b1100110, 1'b1, 1'b1, 1'b0}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclM = 1'b1, sdaM = 1'b1;
  logic [6:0] ownAddr = '0, addrMask = '0;
  logic gcEnable = 1'b0, ackAllow = 1'b1;
  logic sdaOe, sclOe, ackReq, rxRw, gcHit;
  logic [6:0] rxAddr;
  logic sclBus, sdaBus;
  int total = 0, bad = 0;
  logic ackSeen;

  always #5 clk = ~clk;

  assign sclBus = sclM & ~sclOe;
  assign sdaBus = sdaM & ~sdaOe;

  i2c_mask_addr_slave dut_i (
    .clk(clk), .rstN(rstN), .sclIn(sclBus), .sdaIn(sdaBus),
    .ownAddr(ownAddr), .addrMask(addrMask), .gcEnable(gcEnable),
    .ackAllow(ackAllow), .sdaOe(sdaOe), .sclOe(sclOe), .ackReq(ackReq),
    .rxAddr(rxAddr), .rxRw(rxRw), .gcHit(gcHit)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input logic ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic busStart();
    sdaM = 1'b1; tick(H);
    sclM = 1'b1; tick(H);
    sdaM = 1'b0; tick(H);
    sclM = 1'b0; tick(H);
  endtask

  task automatic busStop();
    sdaM = 1'b0; tick(H);
    sclM = 1'b1; tick(H);
    sdaM = 1'b1; tick(H);
  endtask

  task automatic sendBit(input logic b);
    sdaM = b; tick(H);
    sclM = 1'b1;
    while (!sclBus) tick(1);
    tick(H);
    sclM = 1'b0; tick(H);
  endtask

  task automatic sendByte(input logic [6:0] a, input logic rw);
    for (int i = 6; i >= 0; i--) sendBit(a[i]);
    sendBit(rw);
  endtask

  // ninth clock; the master leaves SDA released and looks for a low
  task automatic ackBit();
    sdaM = 1'b1;
    sclM = 1'b1;
    while (!sclBus) tick(1);
    tick(H / 2);
    ackSeen = ~sdaBus;
    tick(H / 2);
    sclM = 1'b0; tick(H);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    tick(4);
    // reset state
    check(sdaOe == 1'b0 && sclOe == 1'b0 && ackReq == 1'b0, "R9 reset outputs",
          {sdaOe, sclOe, ackReq}, 0);
    check(rxAddr == 7'd0 && gcHit == 1'b0, "R5 reset report", rxAddr, 0);
    rstN = 1'b1;
    tick(4);

    // R1 R2 R3 R4 R5 R10 table walk
    for (int v = 0; v < NV; v++) begin
      logic [6:0] prevAddr;
      logic prevRw;
      prevAddr = rxAddr;
      prevRw   = rxRw;
      addrMask = VEC[v][24:18];
      ownAddr  = VEC[v][17:11];
      gcEnable = VEC[v][10];
      busStart();
      sendByte(VEC[v][9:3], VEC[v][2]);
      ackBit();
      check(ackSeen == VEC[v][1], "R1 R2 R4 acknowledge", ackSeen, VEC[v][1]);
      check(sdaOe == 1'b0, "R7 SDA released", sdaOe, 0);
      if (VEC[v][1]) begin
        check(rxAddr == VEC[v][9:3], "R5 R10 address", rxAddr, VEC[v][9:3]);
        check(rxRw == VEC[v][2], "R10 direction", rxRw, VEC[v][2]);
        check(gcHit == VEC[v][0], "R3 general call flag", gcHit, VEC[v][0]);
      end else begin
        check(rxAddr == prevAddr && rxRw == prevRw, "R5 unchanged on mismatch",
              {rxAddr, rxRw}, {prevAddr, prevRw});
      end
      busStop();
      tick(H);
    end

    // R6: stretch while the host withholds the grant
    addrMask = 7'd0; ownAddr = 7'h2A; gcEnable = 1'b0;
    ackAllow = 1'b0;
    busStart();
    sendByte(7'h2A, 1'b0);
    tick(30);
    check(sclOe == 1'b1 && ackReq == 1'b1, "R6 stretch held", {sclOe, ackReq}, 3);
    check(sdaOe == 1'b0, "R6 no ack before grant", sdaOe, 0);
    check(rxAddr == 7'h2A, "R5 valid with request", rxAddr, 7'h2A);
    ackAllow = 1'b1;
    tick(3);
    check(sclOe == 1'b0 && sdaOe == 1'b1, "R7 SDA low at release", {sclOe, sdaOe}, 1);
    ackBit();
    check(ackSeen == 1'b1, "R6 acknowledge after grant", ackSeen, 1);
    check(sdaOe == 1'b0, "R7 released after ninth clock", sdaOe, 0);
    busStop();

    // R8: repeated START in the middle of a byte
    ownAddr = 7'h55;
    busStart();
    sendBit(1'b0); sendBit(1'b0); sendBit(1'b1); sendBit(1'b1);
    busStart();
    sendByte(7'h55, 1'b1);
    ackBit();
    check(ackSeen == 1'b1, "R8 ack after repeated start", ackSeen, 1);
    check(rxAddr == 7'h55 && rxRw == 1'b1, "R8 address after repeated start",
          {rxAddr, rxRw}, {7'h55, 1'b1});
    busStop();

    // R9: clocks after STOP with no START are ignored
    ownAddr = 7'h11;
    sclM = 1'b0; tick(H);
    sendByte(7'h11, 1'b0);
    ackBit();
    check(ackSeen == 1'b0, "R9 no ack without start", ackSeen, 0);
    check(rxAddr == 7'h55, "R9 report unchanged", rxAddr, 7'h55);
    sclM = 1'b1; tick(H);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule